// File: doc/BRIEF.md
# Asynchronous Backplane Bus Slave

This block is a target for single read and write cycles on an asynchronous parallel backplane bus that uses a four-edge handshake. The master first places the address, a 6-bit address modifier and the long-word line on the bus. It then lowers the address strobe and, for the data phase, one or both data strobes. The slave brings every strobe into its own clock domain through a short synchroniser chain. It takes the address phase when the synchronised address strobe goes low and decides whether it is addressed by checking two things: whether the modifier is one it accepts, and whether the address lies in a window that starts at the base given on `base_i`.

The bus carries no bit-zero address line. The transfer width (one, two or four bytes) and the byte position are encoded in the two data strobes, the long-word line and address bit 1. A selected access reaches a small local register file with big-endian byte packing. A legal access is answered on the acknowledge line. A width the slave does not support, or one that is misaligned, is answered on the error line. The slave holds its answer, and on a read also holds the read data, until the master releases both data strobes. It then releases the answer and waits for the address strobe to rise before it accepts a new cycle.

Top module: `async_bus_slave`

## Requirements
- R1: After reset `dtack_no` and `berr_no` are high, `data_oe_o` is low and every register word reads as zero.
- R2: Only modifier codes 0x09 and 0x0D (32-bit address), 0x39 and 0x3D (24-bit) and 0x29 and 0x2D (16-bit) select the slave. Any other code gets no response, and a write with such a code leaves the registers unchanged.
- R3: The slave is selected only when the address bits from bit 6 (WIN_BITS) up to the top of the modifier's address width equal the same bits of `base_i`. Address bits above that width are ignored. A cycle outside the window gets no response and changes no register.
- R4: The transfer width is decoded from the active-low strobes. With DS0 and DS1 both low and LWORD low, the access is 32 bits when A1=0. With DS0 and DS1 both low and LWORD high, it is 16 bits. With only DS1 low and LWORD high, it is the even byte. With only DS0 low and LWORD high, it is the odd byte.
- R5: A 32-bit access with A1=1 is answered with `berr_no` low and changes no register. So is a single-byte access with LWORD low.
- R6: Byte order is big endian. Register word n holds byte offsets 4n to 4n+3, with offset 4n in bits 31:24. 32-bit data uses D31:0. 16-bit data uses D15:0 and holds the upper half when A1=0. An even byte uses D15:8 and an odd byte uses D7:0. On a read, lanes outside the access read zero.
- R7: A write updates only the bytes that the access selects. A following read of the same word returns the merged value.
- R8: Once asserted, `dtack_no` or `berr_no` stays low until both data strobes have been seen high. The slave then releases it within a few clock cycles.
- R9: During a read acknowledge, `data_oe_o` is high and `data_o` stays stable until the strobes are released. `data_oe_o` is never high during a write.
- R10: `dtack_no` and `berr_no` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slave clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| as_ni | input | 1 | Address strobe, active low |
| ds0_ni | input | 1 | Odd-byte data strobe, active low |
| ds1_ni | input | 1 | Even-byte data strobe, active low |
| lword_ni | input | 1 | Long-word line, active low |
| write_ni | input | 1 | Direction, low for write |
| addr_i | input | 31 | Address lines 31:1 |
| am_i | input | 6 | Address modifier |
| data_i | input | 32 | Write data from the bus |
| base_i | input | 32 | Window base address |
| data_o | output | 32 | Read data to the bus |
| data_oe_o | output | 1 | Read data drive enable |
| dtack_no | output | 1 | Acknowledge, active low |
| berr_no | output | 1 | Bus error, active low |

## Verification
The hardest situation to reach is a cycle whose modifier selects the 16-bit or 24-bit space while the unused upper address bits carry arbitrary values. That cycle must still hit. A neighbouring cycle whose compared bits differ by a single position must then miss and leave storage untouched. Random stimulus builds in-window addresses for each space by keeping the base bits inside the address width and randomising the bits above it. It mixes these with out-of-window addresses and foreign modifier codes. Later reads through a reference model expose any write that should have been ignored. The strobe combinations are drawn so that misaligned and unsupported widths land inside the window, where only the error line may answer.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  typedef enum logic [2:0] {
    XK_BAD   = 3'd0,
    XK_D32   = 3'd1,
    XK_D16   = 3'd2,
    XK_BEVEN = 3'd3,
    XK_BODD  = 3'd4
  } xfer_kind_e;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_A16  = 2'd1,
    SP_A24  = 2'd2,
    SP_A32  = 2'd3
  } addr_space_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR    = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_ACK     = 3'd3,
    ST_RELEASE = 3'd4,
    ST_SKIP    = 3'd5
  } slv_state_e;

  function automatic addr_space_e am_space(input logic [5:0] am);
    case (am)
      6'h09, 6'h0D: am_space = SP_A32;
      6'h39, 6'h3D: am_space = SP_A24;
      6'h29, 6'h2D: am_space = SP_A16;
      default:      am_space = SP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/vbs_sync.sv
module vbs_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/vbs_decode.sv
module vbs_decode
  import vbs_pkg::*;
#(
  parameter int WIN_BITS = 6,
  localparam int IDX_W   = WIN_BITS - 2
) (
  input  logic [31:1]    addr_i,
  input  logic [5:0]     am_i,
  input  logic [31:0]    base_i,
  input  logic           lword_ni,
  input  logic           ds0_ni,
  input  logic           ds1_ni,
  output logic           hit_o,
  output xfer_kind_e     kind_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [31:0] WIN_MASK = ~((32'd1 << WIN_BITS) - 32'd1);

  addr_space_e space;
  logic [31:0] full_addr;
  logic [31:0] width_mask;

  assign space     = am_space(am_i);
  assign full_addr = {addr_i, 1'b0};

  always_comb begin
    case (space)
      SP_A32:  width_mask = 32'hFFFF_FFFF;
      SP_A24:  width_mask = 32'h00FF_FFFF;
      SP_A16:  width_mask = 32'h0000_FFFF;
      default: width_mask = 32'h0000_0000;
    endcase
  end

  assign hit_o = (space != SP_NONE) &&
                 (((full_addr ^ base_i) & width_mask & WIN_MASK) == 32'd0);

  assign idx_o = full_addr[WIN_BITS-1:2];

  // width from active-low strobes; A1 only matters for the long word
  always_comb begin
    kind_o = XK_BAD;
    unique case ({ds1_ni, ds0_ni, lword_ni})
      3'b000:  kind_o = addr_i[1] ? XK_BAD : XK_D32;
      3'b001:  kind_o = XK_D16;
      3'b011:  kind_o = XK_BEVEN;
      3'b101:  kind_o = XK_BODD;
      default: kind_o = XK_BAD;
    endcase
  end
endmodule

// File: rtl/vbs_lanes.sv
module vbs_lanes
  import vbs_pkg::*;
(
  input  xfer_kind_e  kind_i,
  input  logic        a1_i,
  input  logic [31:0] bus_wdata_i,
  input  logic [31:0] reg_rdata_i,
  output logic [31:0] reg_wdata_o,
  output logic [3:0]  reg_be_o,
  output logic [31:0] bus_rdata_o
);
  logic [15:0] half;

  assign half = a1_i ? reg_rdata_i[15:0] : reg_rdata_i[31:16];

  always_comb begin
    reg_wdata_o = a1_i ? {16'h0, bus_wdata_i[15:0]} : {bus_wdata_i[15:0], 16'h0};
    reg_be_o    = 4'b0000;
    bus_rdata_o = 32'h0;
    case (kind_i)
      XK_D32: begin
        reg_wdata_o = bus_wdata_i;
        reg_be_o    = 4'b1111;
        bus_rdata_o = reg_rdata_i;
      end
      XK_D16: begin
        reg_be_o    = a1_i ? 4'b0011 : 4'b1100;
        bus_rdata_o = {16'h0, half};
      end
      XK_BEVEN: begin
        reg_be_o    = a1_i ? 4'b0010 : 4'b1000;
        bus_rdata_o = {16'h0, half[15:8], 8'h0};
      end
      XK_BODD: begin
        reg_be_o    = a1_i ? 4'b0001 : 4'b0100;
        bus_rdata_o = {24'h0, half[7:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vbs_regfile.sv
module vbs_regfile #(
  parameter int  WORDS = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [3:0]       be_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [31:0] mem_q [WORDS];

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar b = 0; b < 4; b++) begin : g_byte
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) mem_q[w][8*b +: 8] <= 8'h0;
          else if (we_i && be_i[b] && (idx_i == IDX_W'(w)))
            mem_q[w][8*b +: 8] <= wdata_i[8*b +: 8];
        end
      end
    end
  endgenerate

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/async_bus_slave.sv
module async_bus_slave
  import vbs_pkg::*;
#(
  parameter int WIN_BITS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        as_ni,
  input  logic        ds0_ni,
  input  logic        ds1_ni,
  input  logic        lword_ni,
  input  logic        write_ni,
  input  logic [31:1] addr_i,
  input  logic [5:0]  am_i,
  input  logic [31:0] data_i,
  input  logic [31:0] base_i,
  output logic [31:0] data_o,
  output logic        data_oe_o,
  output logic        dtack_no,
  output logic        berr_no
);
  localparam int WORDS = 1 << (WIN_BITS - 2);
  localparam int IDX_W = WIN_BITS - 2;

  logic as_s, ds0_s, ds1_s, wr_s;

  vbs_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({as_ni, ds0_ni, ds1_ni, write_ni}),
    .q_o    ({as_s, ds0_s, ds1_s, wr_s})
  );

  slv_state_e  state_q;
  logic [31:1] addr_q;
  logic [5:0]  am_q;
  logic        lword_q;
  logic        dtack_q, berr_q, oe_q;
  logic [31:0] rd_q;

  logic             hit;
  xfer_kind_e       kind;
  logic [IDX_W-1:0] idx;

  vbs_decode #(.WIN_BITS(WIN_BITS)) u_decode (
    .addr_i   (addr_q),
    .am_i     (am_q),
    .base_i   (base_i),
    .lword_ni (lword_q),
    .ds0_ni   (ds0_s),
    .ds1_ni   (ds1_s),
    .hit_o    (hit),
    .kind_o   (kind),
    .idx_o    (idx)
  );

  logic [31:0] reg_rdata, reg_wdata, bus_rdata;
  logic [3:0]  reg_be;
  logic        reg_we;

  vbs_lanes u_lanes (
    .kind_i      (kind),
    .a1_i        (addr_q[1]),
    .bus_wdata_i (data_i),
    .reg_rdata_i (reg_rdata),
    .reg_wdata_o (reg_wdata),
    .reg_be_o    (reg_be),
    .bus_rdata_o (bus_rdata)
  );

  assign reg_we = (state_q == ST_SETTLE) && hit && (kind != XK_BAD) && !wr_s;

  vbs_regfile #(.WORDS(WORDS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .be_i    (reg_be),
    .idx_i   (idx),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata)
  );

  logic ds_any_low, ds_both_high;
  assign ds_any_low   = !ds0_s || !ds1_s;
  assign ds_both_high = ds0_s && ds1_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      am_q    <= '0;
      lword_q <= 1'b1;
      dtack_q <= 1'b0;
      berr_q  <= 1'b0;
      oe_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (!as_s) begin
          addr_q  <= addr_i;
          am_q    <= am_i;
          lword_q <= lword_ni;
          state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          if (as_s)         state_q <= ST_IDLE;
          else if (!hit)    state_q <= ST_SKIP;
          else if (ds_any_low) state_q <= ST_SETTLE;
        end
        // one extra cycle so both strobes are seen after skew
        ST_SETTLE: begin
          if (kind == XK_BAD) begin
            berr_q <= 1'b1;
          end else begin
            dtack_q <= 1'b1;
            if (wr_s) begin
              rd_q <= bus_rdata;
              oe_q <= 1'b1;
            end
          end
          state_q <= ST_ACK;
        end
        ST_ACK: if (ds_both_high) begin
          dtack_q <= 1'b0;
          berr_q  <= 1'b0;
          oe_q    <= 1'b0;
          rd_q    <= '0;
          state_q <= ST_RELEASE;
        end
        ST_RELEASE: if (as_s) state_q <= ST_IDLE;
        ST_SKIP:    if (as_s) state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign dtack_no  = !dtack_q;
  assign berr_no   = !berr_q;
  assign data_oe_o = oe_q;
  assign data_o    = rd_q;

  AST_ACK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dtack_no && !berr_no)); // R10
  AST_DTACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_no && !ds_both_high) |=> !dtack_no); // R8
  AST_BERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!berr_no && !ds_both_high) |=> !berr_no); // R8
  AST_DTACK_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dtack_no) |-> $past(ds_both_high)); // R8
  AST_RD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o)); // R9
  AST_OE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (wr_s && !dtack_no)); // R9
  AST_BAD_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE && kind == XK_BAD) |=> (!berr_no && dtack_no)); // R5
endmodule

// File: tb/async_bus_slave_test.sv
`timescale 1ns/1ps
module async_bus_slave_test;
  localparam logic [31:0] BASE = 32'hA5C3_4E40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        as_ni = 1'b1, ds0_ni = 1'b1, ds1_ni = 1'b1;
  logic        lword_ni = 1'b1, write_ni = 1'b1;
  logic [31:1] addr_i = '0;
  logic [5:0]  am_i = '0;
  logic [31:0] data_i = '0;
  logic [31:0] base_i = BASE;
  logic [31:0] data_o;
  logic        data_oe_o, dtack_no, berr_no;

  always #2.5 clk_i = ~clk_i;

  async_bus_slave uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .as_ni(as_ni), .ds0_ni(ds0_ni),
    .ds1_ni(ds1_ni), .lword_ni(lword_ni), .write_ni(write_ni),
    .addr_i(addr_i), .am_i(am_i), .data_i(data_i), .base_i(base_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .dtack_no(dtack_no),
    .berr_no(berr_no)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] model [16];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int space_of(input logic [5:0] am);
    case (am)
      6'h09, 6'h0D: return 32;
      6'h39, 6'h3D: return 24;
      6'h29, 6'h2D: return 16;
      default:      return 0;
    endcase
  endfunction

  function automatic bit exp_hit(input logic [5:0] am, input logic [31:0] a);
    logic [31:0] m;
    case (space_of(am))
      32: m = 32'hFFFF_FFC0;
      24: m = 32'h00FF_FFC0;
      16: m = 32'h0000_FFC0;
      default: return 0;
    endcase
    return ((a ^ BASE) & m) == 0;
  endfunction

  // 0 bad, 1 D32, 2 D16, 3 even byte, 4 odd byte
  function automatic int exp_kind(input bit d0n, input bit d1n, input bit lwn, input bit a1);
    if (!d0n && !d1n && !lwn) return a1 ? 0 : 1;
    if (!d0n && !d1n && lwn)  return 2;
    if (d0n && !d1n && lwn)   return 3;
    if (!d0n && d1n && lwn)   return 4;
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(input int k, input bit a1, input logic [31:0] w);
    logic [15:0] h;
    h = a1 ? w[15:0] : w[31:16];
    case (k)
      1: return w;
      2: return {16'h0, h};
      3: return {16'h0, h[15:8], 8'h0};
      4: return {24'h0, h[7:0]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_write(input int k, input bit a1, input logic [31:0] w, input logic [31:0] d);
    logic [31:0] r;
    r = w;
    case (k)
      1: r = d;
      2: if (a1) r[15:0] = d[15:0]; else r[31:16] = d[15:0];
      3: if (a1) r[15:8] = d[15:8]; else r[31:24] = d[15:8];
      4: if (a1) r[7:0] = d[7:0]; else r[23:16] = d[7:0];
      default: ;
    endcase
    return r;
  endfunction

  // one full handshake; resp 0 none, 1 dtack, 2 berr
  task automatic bus_cycle(input logic [5:0] am, input logic [31:0] a, input bit wr,
                           input bit d0n, input bit d1n, input bit lwn, input logic [31:0] wd,
                           output int resp, output logic [31:0] rd, output bit hold_ok,
                           output bit rel_ok, output bit oe);
    @(negedge clk_i);
    addr_i = a[31:1]; am_i = am; lword_ni = lwn; write_ni = !wr; data_i = wd;
    @(negedge clk_i);
    as_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    ds0_ni = d0n; ds1_ni = d1n;
    resp = 0; rd = '0; hold_ok = 1; rel_ok = 1; oe = 0;
    for (int i = 0; i < 16 && resp == 0; i++) begin
      @(negedge clk_i);
      if (!dtack_no) resp = 1;
      else if (!berr_no) resp = 2;
    end
    if (resp != 0) begin
      rd = data_o; oe = data_oe_o;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk_i);
        if (resp == 1 && dtack_no) hold_ok = 0;
        if (resp == 2 && berr_no) hold_ok = 0;
        if (!dtack_no && !berr_no) hold_ok = 0;
        if (data_o != rd || data_oe_o != oe) hold_ok = 0;
      end
    end
    ds0_ni = 1'b1; ds1_ni = 1'b1;
    rel_ok = 0;
    for (int i = 0; i < 16 && !rel_ok; i++) begin
      @(negedge clk_i);
      if (dtack_no && berr_no && !data_oe_o) rel_ok = 1;
    end
    as_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic run(input logic [5:0] am, input logic [31:0] a, input bit wr,
                     input bit d0n, input bit d1n, input bit lwn, input logic [31:0] wd);
    int resp, eresp, k;
    logic [31:0] rd, er;
    bit hold_ok, rel_ok, oe, h;
    h = exp_hit(am, a);
    k = exp_kind(d0n, d1n, lwn, a[1]);
    eresp = !h ? 0 : (k == 0 ? 2 : 1);
    bus_cycle(am, a, wr, d0n, d1n, lwn, wd, resp, rd, hold_ok, rel_ok, oe);
    if (!h) check(resp == 0, "R2/R3 no response", resp, 0);
    else if (k == 0) check(resp == 2, "R5 error answer", resp, 2);
    else check(resp == 1, "R4 acknowledge", resp, 1);
    if (resp != 0) check(hold_ok, "R8 answer held", {31'h0, hold_ok}, 1);
    check(rel_ok, "R8 release", {31'h0, rel_ok}, 1);
    if (eresp == 1 && !wr) begin
      er = exp_read(k, a[1], model[a[5:2]]);
      check(rd == er, "R6 read data", rd, er);
      check(oe, "R9 drive enable", {31'h0, oe}, 1);
    end
    if (wr) check(!oe, "R9 no drive on write", {31'h0, oe}, 0);
    if (eresp == 1 && wr) model[a[5:2]] = exp_write(k, a[1], model[a[5:2]], wd);
  endtask

  task automatic read_word(input logic [3:0] w, input string req);
    int resp;
    logic [31:0] rd;
    bit hold_ok, rel_ok, oe;
    bus_cycle(6'h09, BASE | {26'h0, w, 2'b00}, 0, 0, 0, 0, 32'h0, resp, rd, hold_ok, rel_ok, oe);
    check(resp == 1 && rd == model[w], req, rd, model[w]);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] ams [6];
    ams = '{6'h09, 6'h0D, 6'h39, 6'h3D, 6'h29, 6'h2D};
    void'($urandom(32'h0BA5E));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    check(dtack_no && berr_no && !data_oe_o, "R1 reset outputs",
          {29'h0, dtack_no, berr_no, data_oe_o}, 32'h6);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    for (int w = 0; w < 16; w++) read_word(4'(w), "R1 reset register");

    // directed corners
    run(6'h09, BASE | 32'h4, 1, 0, 0, 0, 32'h1122_3344);          // R4 D32
    read_word(4'd1, "R7 long word");
    run(6'h0D, BASE | 32'h6, 1, 0, 0, 1, 32'h0000_AABB);          // R6 D16 low half
    run(6'h0D, BASE | 32'h4, 0, 0, 1, 1, 32'h0);                   // R6 odd byte upper half
    run(6'h09, BASE | 32'h6, 0, 1, 0, 1, 32'h0);                   // R6 even byte lower half
    read_word(4'd1, "R7 merged half");
    run(6'h09, BASE | 32'h8, 1, 1, 0, 1, 32'h0000_CD00);          // R7 even byte write
    run(6'h09, BASE | 32'h8, 1, 0, 1, 1, 32'h0000_00EF);          // R7 odd byte write
    read_word(4'd2, "R7 byte merge");
    run(6'h09, BASE | 32'hE, 1, 0, 0, 0, 32'hDEAD_BEEF);          // R5 misaligned long
    run(6'h09, BASE | 32'hC, 1, 0, 1, 0, 32'hDEAD_BEEF);          // R5 byte with lword
    read_word(4'd3, "R5 no change");
    run(6'h3F, BASE | 32'hC, 1, 0, 0, 0, 32'h1234_5678);          // R2 foreign code
    run(6'h09, BASE ^ 32'h40, 1, 0, 0, 0, 32'h1234_5678);         // R3 one bit outside
    run(6'h39, {8'h5A, BASE[23:0]} | 32'h10, 1, 0, 0, 0, 32'hCAFE_F00D); // R3 upper ignored
    run(6'h29, {16'h0F0F, BASE[15:0]} | 32'h14, 1, 0, 0, 0, 32'h0BAD_C0DE);
    run(6'h29, {BASE[31:16], BASE[15:0] ^ 16'h0100}, 1, 0, 0, 0, 32'h1);
    read_word(4'd3, "R2 R3 ignored");
    read_word(4'd4, "R3 A24 hit");
    read_word(4'd5, "R3 A16 hit");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] am;
      logic [31:0] a;
      int sp, pat;
      bit d0n, d1n;
      am = ($urandom % 5 != 0) ? ams[$urandom % 6] : 6'($urandom);
      sp = space_of(am);
      a = $urandom;
      if ($urandom % 4 != 0) begin
        if (sp == 24) a = {a[31:24], BASE[23:6], a[5:0]};
        else if (sp == 16) a = {a[31:16], BASE[15:6], a[5:0]};
        else a = {BASE[31:6], a[5:0]};
      end
      pat = $urandom % 3;
      d0n = (pat == 1); d1n = (pat == 2);
      run(am, a, 1'($urandom), d0n, d1n, 1'($urandom), $urandom);
    end
    for (int w = 0; w < 16; w++) read_word(4'(w), "R7 final contents");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule